// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a small general-purpose I/O port of up to sixteen pins (twelve by default) that sits behind a simple 32-bit register bus. Each pin carries a stored output value, a direction bit that enables its output driver, and a synchronized input sample that software can read back. Reads are combinational from the current register state; writes are captured on the rising clock edge when select and write are both high.

Every pin also has an interrupt detector whose trigger can be set per pin to a rising edge, a falling edge, either edge, a high level or a low level. Detected events latch into a per-pin status bit, but only while that pin's enable bit is set. Software clears status bits by writing ones. A mask, set and cleared through two separate write-one registers, hides status bits from the single interrupt request output. A software reset register and a plain stored pin-select register complete the map.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After the reset input every readable register returns 0, `pin_oe` and `pin_out` are 0 and `irq_req` is 0.
- R2: Word 0x20 (direction) drives `pin_oe` bit for bit (1 = output) and word 0x18 (output value) drives `pin_out`; both read back as written, limited to the implemented pins.
- R3: Word 0x1C returns `pin_in` after a two-flop synchronizer, so a change at the pins appears on a read after two rising edges and not after one; bits above the pin count read 0.
- R4: Pin k's 3-bit trigger code sits at bits [4m+2:4m] of word 0x24 for pins 0 to 7 (m = k) and of word 0x28 for pins 8 and up (m = k-8); the code bits read back as written and all other bits read 0.
- R5: Trigger code 1 latches status on a rising edge, code 0 on a falling edge and code 4 on either edge, once per edge; a pin held steady latches nothing further after a clear. Codes 5 to 7 never trigger.
- R6: Code 3 (high) and code 2 (low) latch status while the level is active; after a clear that coincides with an active level the bit reads 0 for one cycle and 1 again on the next.
- R7: A status bit (word 0x04) can become set only while the pin's enable bit in word 0x00 is 1; events on disabled pins are lost.
- R8: Writing ones to word 0x0C clears those status bits, zero bits leave status unchanged, and a clear takes priority over a detection in the same cycle.
- R9: Ones written to word 0x10 set mask bits, ones written to word 0x14 clear them, zero bits leave the mask unchanged; word 0x10 reads the mask and word 0x14 reads 0. Word 0x08 returns status AND NOT mask and `irq_req` is the OR of those bits.
- R10: Words 0x2C, 0x30 and 0x34 read 0 and ignore writes; writes to the status word 0x04 and the displayed word 0x08 have no effect.
- R11: Word 0x38 stores one select bit per pin and reads it back; writing 1 then 0 to bit 0 of word 0x3C returns every other register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | NUM_PINS | Sampled pin levels |
| pin_out | output | NUM_PINS | Output value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq_req | output | 1 | OR of unmasked latched status bits |

## Verification
A status clear write and a fresh detection can land on the same clock edge, and the block resolves this by letting the clear win. The bench provokes the collision with a pin held at its active level in a level-triggered mode, clears it, and judges the result by reading status in the very next cycle (expected 0) and once more a cycle later (expected 1). Mask writes landing while a status bit is latched are judged through `irq_req` and the displayed word directly after each write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word indexes (byte address bits [5:2]).
  localparam logic [3:0] W_IEN    = 4'h0;
  localparam logic [3:0] W_STAT   = 4'h1;
  localparam logic [3:0] W_DISP   = 4'h2;
  localparam logic [3:0] W_CLR    = 4'h3;
  localparam logic [3:0] W_MSET   = 4'h4;
  localparam logic [3:0] W_MCLR   = 4'h5;
  localparam logic [3:0] W_OVAL   = 4'h6;
  localparam logic [3:0] W_INP    = 4'h7;
  localparam logic [3:0] W_DIR    = 4'h8;
  localparam logic [3:0] W_MODE_A = 4'h9;
  localparam logic [3:0] W_MODE_B = 4'hA;
  localparam logic [3:0] W_USEL   = 4'hE;
  localparam logic [3:0] W_SRST   = 4'hF;

  localparam int PINS_PER_MODE_WORD = 8;
  localparam int MODE_STRIDE        = 4;

  typedef enum logic [2:0] {
    TRIG_FALL   = 3'd0,
    TRIG_RISE   = 3'd1,
    TRIG_LVL_LO = 3'd2,
    TRIG_LVL_HI = 3'd3,
    TRIG_ANY    = 3'd4
  } trig_e;

  // Detection for one pin from its current and previous synchronized level.
  function automatic logic trig_hit(input logic [2:0] code, input logic cur, input logic prev);
    case (code)
      TRIG_FALL:   return ~cur & prev;
      TRIG_RISE:   return cur & ~prev;
      TRIG_LVL_LO: return ~cur;
      TRIG_LVL_HI: return cur;
      TRIG_ANY:    return cur ^ prev;
      default:     return 1'b0;
    endcase
  endfunction

  // Lowest bit of a pin's code field inside its mode word.
  function automatic int field_lsb(input int pin);
    return MODE_STRIDE * (pin % PINS_PER_MODE_WORD);
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      dout    <= '0;
    end else begin
      stage_q <= din;
      dout    <= stage_q;
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [2:0] code,
  output logic       hit
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign hit = trig_hit(code, lvl, prev_q);

  // Edge triggers only fire when the synchronized level has just moved.
  p_edge_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (code == TRIG_RISE || code == TRIG_FALL || code == TRIG_ANY))
      |-> (lvl != $past(lvl)));

  // Unused codes never trigger.
  p_bad_code_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code > 3'd4) |-> !hit);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [5:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_req
);

  localparam int PW = NUM_PINS;

  logic [PW-1:0] ien_q, stat_q, mask_q, oval_q, dir_q, usel_q;
  logic          srst_q;
  logic [2:0]    code_q [PW];

  logic [PW-1:0] lvl, hit, set_vec, clr_vec, wdat_p, disp;
  logic [3:0]    word;
  logic          wr_en;
  logic          unused_bus;

  assign word       = bus_addr[5:2];
  assign wr_en      = bus_sel & bus_wr;
  assign wdat_p     = bus_wdata[PW-1:0];
  assign unused_bus = ^{bus_addr[1:0], bus_wdata};

  // Named event vectors for the assertions.
  assign clr_vec = (wr_en && word == W_CLR) ? wdat_p : '0;
  assign set_vec = hit & ien_q;

  gpio_pin_sync #(.WIDTH(PW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (lvl)
  );

  for (genvar g = 0; g < PW; g++) begin : g_det
    gpio_irq_detect u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (lvl[g]),
      .code (code_q[g]),
      .hit  (hit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      stat_q <= '0;
      mask_q <= '0;
      oval_q <= '0;
      dir_q  <= '0;
      usel_q <= '0;
      srst_q <= 1'b0;
      for (int k = 0; k < PW; k++) code_q[k] <= '0;
    end else begin
      if (wr_en && word == W_SRST) srst_q <= bus_wdata[0];
      if (srst_q) begin
        ien_q  <= '0;
        stat_q <= '0;
        mask_q <= '0;
        oval_q <= '0;
        dir_q  <= '0;
        usel_q <= '0;
        for (int k = 0; k < PW; k++) code_q[k] <= '0;
      end else begin
        stat_q <= (stat_q | set_vec) & ~clr_vec;
        if (wr_en) begin
          case (word)
            W_IEN:  ien_q  <= wdat_p;
            W_MSET: mask_q <= mask_q | wdat_p;
            W_MCLR: mask_q <= mask_q & ~wdat_p;
            W_OVAL: oval_q <= wdat_p;
            W_DIR:  dir_q  <= wdat_p;
            W_USEL: usel_q <= wdat_p;
            default: ;
          endcase
          for (int k = 0; k < PW; k++) begin
            if ((k < PINS_PER_MODE_WORD) ? (word == W_MODE_A) : (word == W_MODE_B))
              code_q[k] <= bus_wdata[field_lsb(k) +: 3];
          end
        end
      end
    end
  end

  assign disp    = stat_q & ~mask_q;
  assign irq_req = |disp;
  assign pin_out = oval_q;
  assign pin_oe  = dir_q;

  always_comb begin
    bus_rdata = '0;
    case (word)
      W_IEN:  bus_rdata[PW-1:0] = ien_q;
      W_STAT: bus_rdata[PW-1:0] = stat_q;
      W_DISP: bus_rdata[PW-1:0] = disp;
      W_MSET: bus_rdata[PW-1:0] = mask_q;
      W_OVAL: bus_rdata[PW-1:0] = oval_q;
      W_INP:  bus_rdata[PW-1:0] = lvl;
      W_DIR:  bus_rdata[PW-1:0] = dir_q;
      W_USEL: bus_rdata[PW-1:0] = usel_q;
      W_SRST: bus_rdata[0]      = srst_q;
      W_MODE_A, W_MODE_B: begin
        for (int k = 0; k < PW; k++) begin
          if ((k < PINS_PER_MODE_WORD) == (word == W_MODE_A))
            bus_rdata[field_lsb(k) +: 3] = code_q[k];
        end
      end
      default: ;
    endcase
  end

  // Newly set status bits must have been enabled in the cycle before.
  p_set_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~$past(stat_q) & ~$past(ien_q)) == '0);

  // A clear write leaves its bits at 0 even if a detection coincided.
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & $past(clr_vec)) == '0);

  // The request line never rises without some latched status.
  p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (stat_q != '0));

  // A held software reset leaves the programmable state at defaults.
  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst_q) |-> (ien_q == '0 && stat_q == '0 && mask_q == '0 && dir_q == '0));

endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq_req;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // A pin change shows in status after sync (2) plus latch (1) edges.
  task automatic drive(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
    cyc(4);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    foreach (d[i]) ;
    for (int a = 0; a < 16; a++) begin
      rd(6'(a*4), d);
      check($sformatf("R1 word %0d", a), d, 0);
    end
    check("R1 pin_oe", 32'(pin_oe), 0);
    check("R1 pin_out", 32'(pin_out), 0);
    check("R1 irq_req", 32'(irq_req), 0);
  endtask

  task automatic t_dir_out;
    logic [31:0] d;
    wr(6'h20, 32'hFFFF_F0F5);
    wr(6'h18, 32'h1234_5A5A);
    check("R2 pin_oe", 32'(pin_oe), 32'h0F5);
    check("R2 pin_out", 32'(pin_out), 32'hA5A);
    rd(6'h20, d); check("R2 dir readback", d, 32'h0F5);
    rd(6'h18, d); check("R2 out readback", d, 32'hA5A);
  endtask

  task automatic t_input;
    logic [31:0] d;
    @(negedge clk); pin_in = 12'h9C3;
    @(negedge clk); rd(6'h1C, d); check("R3 after one edge", d, 0);
    @(negedge clk); rd(6'h1C, d); check("R3 after two edges", d, 32'h9C3);
  endtask

  task automatic t_mode_layout;
    logic [31:0] d;
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, d); check("R4 mode word A", d, 32'h7777_7777);
    wr(6'h28, 32'hFFFF_FFFF); rd(6'h28, d); check("R4 mode word B", d, 32'h0000_7777);
    wr(6'h28, 32'h0000_0000);
    // pin0 rise(1), pin1 fall(0), pin2 any(4), pin3 high(3), pin4 low(2)
    wr(6'h24, 32'h0002_3401); rd(6'h24, d); check("R4 mode word A codes", d, 32'h0002_3401);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    drive(12'h000);
    wr(6'h00, 32'h7);
    wr(6'h0C, 32'hFFF);
    rd(6'h04, d); check("R5 idle status", d, 0);
    drive(12'h007);
    rd(6'h04, d); check("R5 rising edges", d, 32'h5);
    wr(6'h0C, 32'h7);
    rd(6'h04, d); check("R5 cleared", d, 0);
    drive(12'h000);
    rd(6'h04, d); check("R5 falling edges", d, 32'h6);
    wr(6'h0C, 32'h7);
    cyc(4);
    rd(6'h04, d); check("R5 no retrigger", d, 0);
  endtask

  task automatic t_levels;
    logic [31:0] d;
    wr(6'h00, 32'h1F);
    cyc(2);
    rd(6'h04, d); check("R6 low level active", d & 32'h18, 32'h10);
    drive(12'h008);
    rd(6'h04, d); check("R6 both levels active", d & 32'h18, 32'h18);
    wr(6'h0C, 32'h18);
    rd(6'h04, d); check("R6 R8 clear wins in its cycle", d & 32'h18, 32'h00);
    @(negedge clk);
    rd(6'h04, d); check("R6 level re-sets next cycle", d & 32'h18, 32'h18);
    drive(12'h010);
    wr(6'h0C, 32'h18);
    rd(6'h04, d); check("R6 inactive cleared", d & 32'h18, 0);
    cyc(2);
    rd(6'h04, d); check("R6 inactive stays clear", d & 32'h18, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    drive(12'h050);
    drive(12'h010);
    rd(6'h04, d); check("R7 disabled pin ignored", d & 32'h40, 0);
    wr(6'h00, 32'h5F);
    drive(12'h050);
    drive(12'h010);
    rd(6'h04, d); check("R7 enabled pin latches", d, 32'h40);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    check("R9 irq with status", 32'(irq_req), 1);
    rd(6'h08, d); check("R9 displayed", d, 32'h40);
    wr(6'h10, 32'h40);
    check("R9 irq masked", 32'(irq_req), 0);
    rd(6'h08, d); check("R9 displayed masked", d, 0);
    rd(6'h04, d); check("R9 raw kept", d, 32'h40);
    wr(6'h14, 32'h0);
    rd(6'h10, d); check("R9 zero unmask no effect", d, 32'h40);
    rd(6'h14, d); check("R9 unmask word reads 0", d, 0);
    wr(6'h14, 32'h40);
    check("R9 irq unmasked", 32'(irq_req), 1);
    wr(6'h0C, 32'h0);
    rd(6'h04, d); check("R8 zero clear no effect", d, 32'h40);
    wr(6'h0C, 32'h40);
    rd(6'h04, d); check("R8 clear", d, 0);
    check("R8 irq drops", 32'(irq_req), 0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    for (int a = 11; a < 14; a++) begin
      wr(6'(a*4), 32'hFFFF_FFFF);
      rd(6'(a*4), d); check($sformatf("R10 reserved word %0d", a), d, 0);
    end
    wr(6'h04, 32'hFFF); wr(6'h08, 32'hFFF);
    rd(6'h04, d); check("R10 status write ignored", d, 0);
    check("R10 irq after status write", 32'(irq_req), 0);
  endtask

  task automatic t_soft_reset;
    logic [31:0] d;
    wr(6'h38, 32'hFFFF_FFFF);
    rd(6'h38, d); check("R11 select readback", d, 32'hFFF);
    wr(6'h10, 32'h3);
    wr(6'h3C, 32'h1);
    wr(6'h3C, 32'h0);
    rd(6'h20, d); check("R11 dir default", d, 0);
    rd(6'h24, d); check("R11 mode default", d, 0);
    rd(6'h00, d); check("R11 enable default", d, 0);
    rd(6'h10, d); check("R11 mask default", d, 0);
    rd(6'h38, d); check("R11 select default", d, 0);
    check("R11 pin_oe default", 32'(pin_oe), 0);
  endtask

  initial begin
    rst_n = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_dir_out();
    t_input();
    t_mode_layout();
    t_edges();
    t_levels();
    t_enable();
    t_mask();
    t_reserved();
    t_soft_reset();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule